// File: doc/BRIEF.md
# Halfword Signed Multiply-Accumulate Unit

This unit executes one signed multiply-accumulate operation on 16-bit halves of two 32-bit source words. It accepts a 32-bit instruction word in one of two encodings. One is a single fixed-width word. The other is a pair of halfwords with the first halfword in the upper bits. The unit decodes the three source indices, the destination index and the two half-select bits. It presents the source indices to an external register-file read port and receives the three operand words back in the same cycle.

The two selected halves are multiplied as two's-complement values. The 32-bit product is added to a signed 32-bit addend, and the low 32 bits are returned with a write enable and a destination index one cycle later. If the addition leaves the signed 32-bit range, a sticky saturation flag is raised. The flag is held until a clear input is pulsed.

Instructions that do not belong to this operation are rejected and reported, and so are instructions that name register 15 where it is not allowed. Instructions whose condition-pass input is low are also blocked. A rejected or blocked instruction produces no write and leaves the flag alone.

Top module: `hmac_unit`

## Requirements
- R1: Select bit N picks the first multiplicand. N=1 takes bits 31:16 of the first source, and N=0 takes bits 15:0. The other half has no effect.
- R2: Select bit M picks the second multiplicand from the second source in the same way.
- R3: One cycle after an accepted instruction, `res_wen`=1, `res_idx` holds the destination index, and `res_data` holds bits 31:0 of signed(op1)*signed(op2)+signed(addend).
- R4: If the exact sum falls outside [-2^31, 2^31-1], `sat_flag` becomes 1 at the same edge as the result. Otherwise the flag keeps its value, and a set flag stays set across later instructions.
- R5: A `sat_clear` pulse clears `sat_flag` at the next edge. When an overflow and a clear arrive in the same cycle, the flag ends up 1.
- R6: With `in_cond_pass`=0, `res_wen` stays 0 and `sat_flag` is unchanged, even for operands that would overflow.
- R7: Fixed-width encoding (`in_enc`=0) fields:
  - bits 31:28 are the condition and must not be 1111;
  - bits 27:20 must be 00010000, bit 7 must be 1 and bit 4 must be 0;
  - destination is 19:16, addend is 15:12, second source is 11:8 and first source is 3:0;
  - M is bit 6 and N is bit 5.
  Any other word sets `res_other` and does not write.
- R8: Halfword-pair encoding (`in_enc`=1) fields:
  - bits 31:20 must be 111110110001 and bits 7:6 must be 00;
  - first source is 19:16, addend is 15:12, destination is 11:8 and second source is 3:0;
  - N is bit 5 and M is bit 4.
- R9: In the halfword-pair encoding, an addend index of 1111 marks another operation. `res_other`=1, `res_illegal`=0 and no write takes place.
- R10: `res_illegal`=1 and no write takes place in two cases:
  - fixed-width encoding with any of the four indices equal to 15;
  - halfword-pair encoding with the destination, first source or second source equal to 15.
- R11: After a synchronous active-low reset, `res_valid`, `res_wen`, `res_illegal`, `res_other` and `sat_flag` are 0.
- R12: While an instruction is presented, `src1_idx`, `src2_idx` and `add_idx` carry its decoded first-source, second-source and addend indices in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_enc | input | 1 | 0 = fixed-width encoding, 1 = halfword-pair encoding |
| in_insn | input | 32 | Instruction word |
| in_cond_pass | input | 1 | Condition already evaluated as true |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| src1_idx | output | 4 | Read index for the first source |
| src2_idx | output | 4 | Read index for the second source |
| add_idx | output | 4 | Read index for the addend |
| src1_data | input | 32 | First source word |
| src2_data | input | 32 | Second source word |
| add_data | input | 32 | Addend word |
| res_valid | output | 1 | An instruction was presented in the previous cycle |
| res_wen | output | 1 | Write the result to the register file |
| res_idx | output | 4 | Destination index |
| res_data | output | 32 | Low 32 bits of the accumulated sum |
| res_illegal | output | 1 | Forbidden register 15 usage |
| res_other | output | 1 | Word is not this operation |
| sat_flag | output | 1 | Sticky signed-overflow flag |

## Verification
An accepted overflowing instruction and a `sat_clear` pulse can meet at the same clock edge, and the sticky flag must then favour the overflow. The bench first gets the flag set through the vector table and clears it on its own. It then issues an overflowing instruction with `sat_clear` held high in that same cycle and expects the flag to read 1 on the following sample. A clear alone and a clear next to a non-overflowing instruction must both leave the flag at 0.

// File: rtl/hmac_pkg.sv
// Shared constants and the decoded-instruction record for the halfword MAC.
// Assumes 16 architectural registers, so every index is 4 bits wide.
package hmac_pkg;

    localparam int IDX_W = 4;
    localparam logic [IDX_W-1:0] IDX_RESERVED = 4'hF;

    // Fixed-width encoding: opcode byte and the forbidden condition value
    localparam logic [7:0]  WIDE_OPC   = 8'h10;
    localparam logic [3:0]  WIDE_NOCND = 4'hF;
    // Halfword-pair encoding: leading 12 bits of the first halfword
    localparam logic [11:0] PAIR_OPC   = 12'hFB1;

    typedef struct packed {
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src1;
        logic [IDX_W-1:0] src2;
        logic [IDX_W-1:0] addi;
        logic             hi1;      // take upper half of first source
        logic             hi2;      // take upper half of second source
        logic             other;    // word is not this operation
        logic             illegal;  // forbidden register 15 usage
    } dec_t;

endpackage

// File: rtl/hmac_decode.sv
// Field decoder for both encodings of the halfword multiply-accumulate.
// Purely combinational. Assumes the caller qualifies the result with its
// own valid strobe; the outputs are meaningful only when a word is present.
module hmac_decode
    import hmac_pkg::*;
(
    input  logic        enc_pair,
    input  logic [31:0] insn,
    output dec_t        dec
);

    logic wide_hit;
    logic pair_hit;
    logic bad_reg;

    // Recognise the fixed bits of each encoding
    always_comb begin
        wide_hit = (insn[31:28] != WIDE_NOCND) && (insn[27:20] == WIDE_OPC)
                   && insn[7] && !insn[4];
        pair_hit = (insn[31:20] == PAIR_OPC) && (insn[7:6] == 2'b00);
    end

    // Extract indices and select bits, then classify the word
    always_comb begin
        if (enc_pair) begin
            dec.src1 = insn[19:16];
            dec.addi = insn[15:12];
            dec.dst  = insn[11:8];
            dec.src2 = insn[3:0];
            dec.hi1  = insn[5];
            dec.hi2  = insn[4];
            dec.other = !pair_hit || (insn[15:12] == IDX_RESERVED);
            bad_reg  = (insn[11:8] == IDX_RESERVED) || (insn[19:16] == IDX_RESERVED)
                       || (insn[3:0] == IDX_RESERVED);
        end else begin
            dec.dst  = insn[19:16];
            dec.addi = insn[15:12];
            dec.src2 = insn[11:8];
            dec.src1 = insn[3:0];
            dec.hi2  = insn[6];
            dec.hi1  = insn[5];
            dec.other = !wide_hit;
            bad_reg  = (insn[19:16] == IDX_RESERVED) || (insn[15:12] == IDX_RESERVED)
                       || (insn[11:8] == IDX_RESERVED) || (insn[3:0] == IDX_RESERVED);
        end
        dec.illegal = !dec.other && bad_reg;
    end

endmodule

// File: rtl/hmac_mac.sv
// Signed halfword multiply followed by a 32-bit signed accumulate.
// Combinational. Assumes DATA_W is even; the product of two HALF_W operands
// always fits in DATA_W bits, so only the addition is checked for overflow.
module hmac_mac #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] src2,
    input  logic [DATA_W-1:0] addend,
    input  logic              hi1,
    input  logic              hi2,
    output logic [DATA_W-1:0] sum,
    output logic              ovf
);

    localparam int HALF_W = DATA_W / 2;

    logic        [DATA_W-1:0] word [2];
    logic                     pick [2];
    logic signed [HALF_W-1:0] opnd [2];
    logic signed [DATA_W-1:0] prod;
    logic signed [DATA_W:0]   wide_sum;

    // Gather the two sources so one generate loop picks both halves
    always_comb begin
        word[0] = src1;
        word[1] = src2;
        pick[0] = hi1;
        pick[1] = hi2;
    end

    for (genvar g = 0; g < 2; g++) begin : g_half
        assign opnd[g] = pick[g] ? word[g][DATA_W-1:HALF_W] : word[g][HALF_W-1:0];
    end

    // Product, sign-extended sum one bit wider, overflow when top two bits differ
    always_comb begin
        prod     = DATA_W'(opnd[0]) * DATA_W'(opnd[1]);
        prod     = opnd[0] * opnd[1];
        wide_sum = {prod[DATA_W-1], prod} + {addend[DATA_W-1], addend};
        sum      = wide_sum[DATA_W-1:0];
        ovf      = wide_sum[DATA_W] ^ wide_sum[DATA_W-1];
    end

endmodule

// File: rtl/hmac_sticky.sv
// Sticky saturation flag: set by an overflow event, cleared by request.
// A set and a clear in the same cycle leave the flag at 1.
module hmac_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Hold, clear, or set the flag; set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~clr) | set;
    end

    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);

endmodule

// File: rtl/hmac_unit.sv
// Halfword signed multiply-accumulate execution unit.
// Decodes either encoding, reads three operands through the register-file
// read port, and registers the write-back one cycle after in_valid.
// Assumes the register file answers reads combinationally and that
// condition evaluation happens upstream and arrives as in_cond_pass.
module hmac_unit
    import hmac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_enc,
    input  logic [31:0]       in_insn,
    input  logic              in_cond_pass,
    input  logic              sat_clear,
    output logic [IDX_W-1:0]  src1_idx,
    output logic [IDX_W-1:0]  src2_idx,
    output logic [IDX_W-1:0]  add_idx,
    input  logic [DATA_W-1:0] src1_data,
    input  logic [DATA_W-1:0] src2_data,
    input  logic [DATA_W-1:0] add_data,
    output logic              res_valid,
    output logic              res_wen,
    output logic [IDX_W-1:0]  res_idx,
    output logic [DATA_W-1:0] res_data,
    output logic              res_illegal,
    output logic              res_other,
    output logic              sat_flag
);

    dec_t              dec;
    logic [DATA_W-1:0] mac_sum;
    logic              mac_ovf;
    logic              accept;

    hmac_decode u_decode (
        .enc_pair (in_enc),
        .insn     (in_insn),
        .dec      (dec)
    );

    assign src1_idx = dec.src1;
    assign src2_idx = dec.src2;
    assign add_idx  = dec.addi;

    hmac_mac #(.DATA_W(DATA_W)) u_mac (
        .src1   (src1_data),
        .src2   (src2_data),
        .addend (add_data),
        .hi1    (dec.hi1),
        .hi2    (dec.hi2),
        .sum    (mac_sum),
        .ovf    (mac_ovf)
    );

    // An instruction takes effect only if legal, ours and condition-passed
    assign accept = in_valid && in_cond_pass && !dec.other && !dec.illegal;

    hmac_sticky u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (accept && mac_ovf),
        .clr   (sat_clear),
        .q     (sat_flag)
    );

    // Register the write-back and status one cycle after the instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_wen     <= 1'b0;
            res_idx     <= '0;
            res_data    <= '0;
            res_illegal <= 1'b0;
            res_other   <= 1'b0;
        end else begin
            res_valid   <= in_valid;
            res_wen     <= accept;
            res_idx     <= dec.dst;
            res_data    <= mac_sum;
            res_illegal <= in_valid && dec.illegal;
            res_other   <= in_valid && dec.other;
        end
    end

    assert_no_wen_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_wen |-> (!res_illegal && !res_other && res_valid));
    assert_wen_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_wen |-> $past(in_cond_pass));
    assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(in_valid && in_cond_pass));

endmodule

// File: tb/test_hmac_unit.sv
module test_hmac_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_enc, in_cond_pass, sat_clear;
    logic [31:0] in_insn;
    logic [3:0]  src1_idx, src2_idx, add_idx;
    logic [31:0] src1_data, src2_data, add_data;
    logic        res_valid, res_wen, res_illegal, res_other, sat_flag;
    logic [3:0]  res_idx;
    logic [31:0] res_data;

    logic [31:0] rf [16];
    int errors = 0;
    int checks = 0;
    logic exp_q = 1'b0;

    always #2 clk = ~clk;

    assign src1_data = rf[src1_idx];
    assign src2_data = rf[src2_idx];
    assign add_data  = rf[add_idx];

    hmac_unit i_hmac_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_enc(in_enc),
        .in_insn(in_insn), .in_cond_pass(in_cond_pass), .sat_clear(sat_clear),
        .src1_idx(src1_idx), .src2_idx(src2_idx), .add_idx(add_idx),
        .src1_data(src1_data), .src2_data(src2_data), .add_data(add_data),
        .res_valid(res_valid), .res_wen(res_wen), .res_idx(res_idx),
        .res_data(res_data), .res_illegal(res_illegal), .res_other(res_other),
        .sat_flag(sat_flag)
    );

    typedef struct packed {
        logic        enc;
        logic        hi1;
        logic        hi2;
        logic        cond;
        logic [3:0]  dst;
        logic [3:0]  s1;
        logic [3:0]  s2;
        logic [3:0]  ad;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic        exp_ovf;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, 4'd3, 4'd4, 32'h0000_0003, 32'h0000_0005, 32'd10,       1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'd5, 4'd6, 4'd7, 4'd8, 32'hFFFE_1234, 32'h7777_0007, 32'd0,        1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 4'd9, 4'd0, 4'd1, 4'd2, 32'h1111_8000, 32'h8000_2222, 32'd0,        1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 4'd3, 4'd4, 4'd5, 4'd6, 32'h7FFF_0000, 32'h7FFF_0000, 32'h7FFF_FFFF, 1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b0, 4'd7, 4'd8, 4'd9, 4'd10, 32'h0000_0003, 32'h0000_0003, 32'd1,       1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'd11, 4'd12, 4'd13, 4'd14, 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 4'd3, 4'd4, 4'd5, 32'hFFFF_FFFF, 32'hABCD_FFFF, 32'h7FFF_FFFE, 1'b0}
    };

    function automatic logic [31:0] mk_wide(logic [3:0] cnd, logic [3:0] d, logic [3:0] s1,
                                            logic [3:0] s2, logic [3:0] ad, logic h1, logic h2);
        return {cnd, 8'h10, d, ad, s2, 1'b1, h2, h1, 1'b0, s1};
    endfunction

    function automatic logic [31:0] mk_pair(logic [3:0] d, logic [3:0] s1,
                                            logic [3:0] s2, logic [3:0] ad, logic h1, logic h2);
        return {12'hFB1, s1, ad, d, 2'b00, h1, h2, s2};
    endfunction

    // Reference model: returns {overflow, low 32 bits}
    function automatic logic [32:0] ref_mac(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                                            logic h1, logic h2);
        longint x, y, s;
        x = h1 ? longint'($signed(a[31:16])) : longint'($signed(a[15:0]));
        y = h2 ? longint'($signed(b[31:16])) : longint'($signed(b[15:0]));
        s = x * y + longint'($signed(c));
        return {(s > 64'sd2147483647) || (s < -64'sd2147483648), s[31:0]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one instruction for a cycle, then sample the registered result
    task automatic issue(logic enc, logic [31:0] insn, logic cnd, logic clr);
        @(negedge clk);
        in_valid = 1'b1; in_enc = enc; in_insn = insn; in_cond_pass = cnd; sat_clear = clr;
        @(negedge clk);
        in_valid = 1'b0; in_cond_pass = 1'b0; sat_clear = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [32:0] r;
        for (int k = 0; k < 16; k++) rf[k] = 32'(k) * 32'h0101_0101;
        rst_n = 1'b0; in_valid = 1'b0; in_enc = 1'b0; in_insn = '0;
        in_cond_pass = 1'b0; sat_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 res_valid", 32'(res_valid), 0);
        check("R11 res_wen", 32'(res_wen), 0);
        check("R11 sat_flag", 32'(sat_flag), 0);
        check("R11 status", {30'd0, res_illegal, res_other}, 0);

        // Vector table: R1 R2 R3 R4 R6 R7 R8 R12
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] w;
            v = VECS[i];
            rf[v.s1] = v.a; rf[v.s2] = v.b; rf[v.ad] = v.c;
            w = v.enc ? mk_pair(v.dst, v.s1, v.s2, v.ad, v.hi1, v.hi2)
                      : mk_wide(4'hE, v.dst, v.s1, v.s2, v.ad, v.hi1, v.hi2);
            r = ref_mac(v.a, v.b, v.c, v.hi1, v.hi2);
            @(negedge clk);
            in_valid = 1'b1; in_enc = v.enc; in_insn = w; in_cond_pass = v.cond;
            #1;
            check("R12 src1 index", 32'(src1_idx), 32'(v.s1));
            check("R12 src2 index", 32'(src2_idx), 32'(v.s2));
            check("R12 addend index", 32'(add_idx), 32'(v.ad));
            @(negedge clk);
            in_valid = 1'b0; in_cond_pass = 1'b0;
            check("R3 res_valid", 32'(res_valid), 1);
            check("R6 res_wen follows condition", 32'(res_wen), 32'(v.cond));
            if (v.cond) begin
                check("R7/R8 res_idx", 32'(res_idx), 32'(v.dst));
                check("R1/R2/R3 res_data", res_data, r[31:0]);
                check("R4 model overflow", 32'(r[32]), 32'(v.exp_ovf));
            end
            exp_q = exp_q | (v.cond & v.exp_ovf);
            check("R4 sat_flag sticky", 32'(sat_flag), 32'(exp_q));
        end

        // R1: the upper half of the first source is ignored when N=0
        rf[2] = 32'hDEAD_0004; rf[3] = 32'h0000_0003; rf[4] = 32'd0;
        issue(1'b0, mk_wide(4'hE, 4'd1, 4'd2, 4'd3, 4'd4, 1'b0, 1'b0), 1'b1, 1'b0);
        check("R1 other half ignored", res_data, 32'd12);
        // R2: the lower half of the second source is ignored when M=1
        rf[3] = 32'hFFFF_7777;
        issue(1'b1, mk_pair(4'd1, 4'd2, 4'd3, 4'd4, 1'b0, 1'b1), 1'b1, 1'b0);
        check("R2 other half ignored", res_data, 32'hFFFF_FFFC);

        // R6: overflowing operands with the condition failed leave the flag alone
        sat_clear = 1'b1; @(negedge clk); sat_clear = 1'b0;
        check("R5 clear alone", 32'(sat_flag), 0);
        rf[5] = 32'h7FFF_7FFF; rf[6] = 32'h7FFF_7FFF; rf[7] = 32'h7FFF_FFFF;
        issue(1'b0, mk_wide(4'hE, 4'd8, 4'd5, 4'd6, 4'd7, 1'b0, 1'b0), 1'b0, 1'b0);
        check("R6 no flag when condition fails", 32'(sat_flag), 0);

        // R10: register 15 usage, overflowing operands, no write, no flag
        issue(1'b0, mk_wide(4'hE, 4'd8, 4'd5, 4'd6, 4'hF, 1'b0, 1'b0), 1'b1, 1'b0);
        check("R10 wide addend 15 illegal", 32'(res_illegal), 1);
        check("R10 wide no write", 32'(res_wen), 0);
        check("R10 flag untouched", 32'(sat_flag), 0);
        issue(1'b1, mk_pair(4'hF, 4'd5, 4'd6, 4'd7, 1'b0, 1'b0), 1'b1, 1'b0);
        check("R10 pair dest 15 illegal", 32'(res_illegal), 1);
        check("R10 pair no write", 32'(res_wen), 0);

        // R9: pair addend 15 is another operation, not illegal
        issue(1'b1, mk_pair(4'd8, 4'd5, 4'd6, 4'hF, 1'b0, 1'b0), 1'b1, 1'b0);
        check("R9 other set", 32'(res_other), 1);
        check("R9 not illegal", 32'(res_illegal), 0);
        check("R9 no write", 32'(res_wen), 0);

        // R7: condition field 1111 and a wrong fixed bit are not this operation
        issue(1'b0, mk_wide(4'hF, 4'd8, 4'd5, 4'd6, 4'd7, 1'b0, 1'b0), 1'b1, 1'b0);
        check("R7 cond 1111 other", 32'(res_other), 1);
        check("R7 cond 1111 no write", 32'(res_wen), 0);
        issue(1'b0, mk_wide(4'hE, 4'd8, 4'd5, 4'd6, 4'd7, 1'b0, 1'b0) | 32'h10, 1'b1, 1'b0);
        check("R7 bit 4 set other", 32'(res_other), 1);
        check("R7 flag untouched", 32'(sat_flag), 0);

        // R5: overflow and clear in the same cycle -> flag ends 1
        issue(1'b0, mk_wide(4'hE, 4'd8, 4'd5, 4'd6, 4'd7, 1'b0, 1'b0), 1'b1, 1'b1);
        check("R5 set wins over clear", 32'(sat_flag), 1);
        check("R4 overflow write still happens", 32'(res_wen), 1);
        // R5: clear together with a non-overflowing instruction -> 0
        issue(1'b0, mk_wide(4'hE, 4'd1, 4'd2, 4'd3, 4'd4, 1'b0, 1'b0), 1'b1, 1'b1);
        check("R5 clear with quiet instruction", 32'(sat_flag), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule